// File: doc/BRIEF.md
# RV32 Immediate Operand Generator

This block turns a 32-bit base-integer instruction word into the sign-extended immediate operand that the execute stage needs. The immediate bits are scattered across the word in a different layout for each instruction format. The block gathers them, takes the sign from instruction bit 31, and applies the implicit one-bit left shift that branch and jump offsets carry. It handles five layouts: register-immediate/load/indirect-jump (I), store (S), conditional branch (B), upper-immediate (U) and direct jump (J).

The block is purely combinational. A 3-bit format select either names the layout directly, when an external decoder has already classified the instruction, or asks the block to classify the instruction itself from its 7-bit opcode. The layout that was actually applied is reported back. The output width is a parameter. When it is wider than 32 bits, the result is sign-extended from bit 31 to fill it.

Top module: `rv_imm_gen`

## Requirements
- R1: The format select is coded as 0 = classify from the opcode, 1 = I, 2 = S, 3 = B, 4 = U, 5 = J, and 6 or 7 = no immediate. A code from 1 to 5 overrides whatever the opcode says.
- R2: The I layout yields instruction bits [31:20] as a signed 12-bit value, extended to the full output width.
- R3: The S layout yields a signed 12-bit value whose upper seven bits are instruction bits [31:25] and whose lower five bits are instruction bits [11:7].
- R4: The B layout yields the signed 13-bit value {inst[31], inst[7], inst[30:25], inst[11:8], 0}. Bit 0 is always 0.
- R5: The U layout places instruction bits [31:12] in result bits [31:12] and clears result bits [11:0].
- R6: The J layout yields the signed 21-bit value {inst[31], inst[19:12], inst[20], inst[30:21], 0}. Bit 0 is always 0.
- R7: For every layout that produces an immediate, every result bit above the layout's own field equals instruction bit 31.
- R8: When classifying from the opcode (bits [6:0]), 0010011, 0000011 and 1100111 give I; 0100011 gives S; 1100011 gives B; 0110111 and 0010111 give U; 1101111 gives J.
- R9: An opcode outside the R8 list in classify mode, or a select of 6 or 7, gives an all-zero immediate.
- R10: The format output reports the applied layout with codes 0 = none, 1 = I, 2 = S, 3 = B, 4 = U, 5 = J.
- R11: Both outputs depend only on the present inputs. There is no storage and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_i | input | ILEN (32) | Instruction word |
| fmt_sel_i | input | 3 | Layout select or classify request (R1) |
| imm_o | output | XLEN (32) | Sign-extended immediate operand |
| fmt_o | output | 3 | Layout that was applied (R10) |

## Verification
Every result is due in the same cycle as the stimulus that produces it, because there is no register between the inputs and the outputs. The bench therefore changes the instruction and the select on the falling clock edge. It compares both outputs against its behavioural model on the following rising edge, which gives the combinational paths half a period to settle and keeps stimulus and sampling on opposite edges. The stimulus starts with directed words that isolate the sign bit and each field boundary in every layout, every listed opcode, and override and reserved select codes. It then moves on to random words, half of which carry a listed opcode.

// File: rtl/rvimm_pkg.sv
package rvimm_pkg;

   typedef enum logic [2:0] {
      FMT_NONE = 3'd0,
      FMT_I    = 3'd1,
      FMT_S    = 3'd2,
      FMT_B    = 3'd3,
      FMT_U    = 3'd4,
      FMT_J    = 3'd5
   } imm_fmt_e;

   localparam int unsigned NUM_FMT  = 5;
   localparam int unsigned SEL_W    = 3;
   localparam logic [2:0]  SEL_AUTO = 3'd0;

   localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;

endpackage

// File: rtl/rvimm_opc_decode.sv
module rvimm_opc_decode
   import rvimm_pkg::*;
#(
   parameter int unsigned OPC_W = 7
) (
   input  logic [OPC_W-1:0] opcode_i,
   output imm_fmt_e         fmt_o
);

   generate
      if (OPC_W != 7) begin : g_bad_opc_w
         $error("rvimm_opc_decode: OPC_W must be 7");
      end
   endgenerate

   always_comb begin
      unique case (opcode_i)
         OPC_OP_IMM, OPC_LOAD, OPC_JALR: fmt_o = FMT_I;
         OPC_STORE:                      fmt_o = FMT_S;
         OPC_BRANCH:                     fmt_o = FMT_B;
         OPC_LUI, OPC_AUIPC:             fmt_o = FMT_U;
         OPC_JAL:                        fmt_o = FMT_J;
         default:                        fmt_o = FMT_NONE;
      endcase
   end

endmodule

// File: rtl/rvimm_field.sv
module rvimm_field
   import rvimm_pkg::*;
#(
   parameter int unsigned ILEN = 32,
   parameter int unsigned XLEN = 32,
   parameter imm_fmt_e    FMT  = FMT_I
) (
   input  logic [ILEN-1:0] inst_i,
   output logic [XLEN-1:0] imm_o
);

   localparam int unsigned SIGN_POS = ILEN - 1;
   localparam int unsigned EXT_W    = XLEN - ILEN;

   logic [ILEN-1:0] raw;
   logic            unused_inst;

   assign unused_inst = ^inst_i;

   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("rvimm_field: ILEN must be 32");
      end
      if (XLEN < ILEN) begin : g_bad_xlen
         $error("rvimm_field: XLEN must not be below ILEN");
      end

      case (FMT)
         FMT_I: begin : g_i
            assign raw = {{20{inst_i[SIGN_POS]}}, inst_i[31:20]};
         end
         FMT_S: begin : g_s
            assign raw = {{20{inst_i[SIGN_POS]}}, inst_i[31:25], inst_i[11:7]};
         end
         FMT_B: begin : g_b
            assign raw = {{19{inst_i[SIGN_POS]}}, inst_i[31], inst_i[7],
                          inst_i[30:25], inst_i[11:8], 1'b0};
         end
         FMT_U: begin : g_u
            assign raw = {inst_i[31:12], 12'b0};
         end
         FMT_J: begin : g_j
            assign raw = {{11{inst_i[SIGN_POS]}}, inst_i[31], inst_i[19:12],
                          inst_i[20], inst_i[30:21], 1'b0};
         end
         default: begin : g_none
            assign raw = '0;
         end
      endcase

      if (XLEN > ILEN) begin : g_wide
         assign imm_o = {{EXT_W{raw[ILEN-1]}}, raw};
      end else begin : g_exact
         assign imm_o = raw;
      end
   endgenerate

endmodule

// File: rtl/rvimm_mux.sv
module rvimm_mux
   import rvimm_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NCAND = NUM_FMT
) (
   input  imm_fmt_e                     fmt_i,
   input  logic [NCAND-1:0][XLEN-1:0]   cand_i,
   output logic [XLEN-1:0]              imm_o
);

   localparam int unsigned CODE_W = $bits(imm_fmt_e);

   always_comb begin
      imm_o = '0;
      for (int unsigned k = 0; k < NCAND; k++) begin
         if (fmt_i == imm_fmt_e'(CODE_W'(k + 1))) begin
            imm_o = imm_o | cand_i[k];
         end
      end
   end

endmodule

// File: rtl/rv_imm_gen.sv
module rv_imm_gen
   import rvimm_pkg::*;
#(
   parameter int unsigned ILEN  = 32,
   parameter int unsigned XLEN  = 32,
   parameter int unsigned OPC_W = 7
) (
   input  logic [ILEN-1:0] inst_i,
   input  logic [2:0]      fmt_sel_i,
   output logic [XLEN-1:0] imm_o,
   output logic [2:0]      fmt_o
);

   imm_fmt_e                      dec_fmt;
   imm_fmt_e                      use_fmt;
   logic [NUM_FMT-1:0][XLEN-1:0]  cand;

   generate
      if (OPC_W >= ILEN) begin : g_bad_opc
         $error("rv_imm_gen: opcode field must be narrower than the word");
      end
   endgenerate

   rvimm_opc_decode #(.OPC_W(OPC_W)) u_dec (
      .opcode_i (inst_i[OPC_W-1:0]),
      .fmt_o    (dec_fmt)
   );

   always_comb begin
      unique case (fmt_sel_i)
         SEL_AUTO: use_fmt = dec_fmt;
         3'd1:     use_fmt = FMT_I;
         3'd2:     use_fmt = FMT_S;
         3'd3:     use_fmt = FMT_B;
         3'd4:     use_fmt = FMT_U;
         3'd5:     use_fmt = FMT_J;
         default:  use_fmt = FMT_NONE;
      endcase
   end

   generate
      for (genvar f = 0; f < NUM_FMT; f++) begin : g_fld
         rvimm_field #(
            .ILEN (ILEN),
            .XLEN (XLEN),
            .FMT  (imm_fmt_e'(3'(f + 1)))
         ) u_fld (
            .inst_i (inst_i),
            .imm_o  (cand[f])
         );
      end
   endgenerate

   rvimm_mux #(.XLEN(XLEN), .NCAND(NUM_FMT)) u_mux (
      .fmt_i  (use_fmt),
      .cand_i (cand),
      .imm_o  (imm_o)
   );

   assign fmt_o = use_fmt;

endmodule

// File: rtl/rvimm_chk.sv
module rvimm_chk #(
   parameter int unsigned ILEN = 32,
   parameter int unsigned XLEN = 32
) (
   input logic [ILEN-1:0] inst_i,
   input logic [2:0]      sel_i,
   input logic [2:0]      fmt_i,
   input logic [XLEN-1:0] imm_i
);

   logic unused_chk;
   assign unused_chk = ^inst_i;

   always_comb begin
      if (sel_i >= 3'd1 && sel_i <= 3'd5) begin
         AST_SEL_EXPLICIT: assert (fmt_i == sel_i); // R1
      end
      if (sel_i >= 3'd6) begin
         AST_SEL_RESERVED: assert (fmt_i == 3'd0); // R1
      end
      if (fmt_i != 3'd0) begin
         AST_SIGN_FROM_TOP: assert (imm_i[XLEN-1] == inst_i[31]); // R7
      end
      if (fmt_i == 3'd1) begin
         AST_I_FIELD: assert (imm_i[10:0] == inst_i[30:20]); // R2
      end
      if (fmt_i == 3'd2) begin
         AST_S_LOW_FIELD: assert (imm_i[4:0] == inst_i[11:7]); // R3
      end
      if (fmt_i == 3'd3) begin
         AST_B_EVEN: assert (imm_i[0] == 1'b0); // R4
      end
      if (fmt_i == 3'd4) begin
         AST_U_LOW_CLEAR: assert (imm_i[11:0] == 12'd0); // R5
      end
      if (fmt_i == 3'd5) begin
         AST_J_EVEN: assert (imm_i[0] == 1'b0); // R6
      end
      if (fmt_i == 3'd0) begin
         AST_NONE_ZERO: assert (imm_i == '0); // R9
      end
      if (sel_i == 3'd0 && inst_i[6:0] == 7'b0100011) begin
         AST_AUTO_STORE: assert (fmt_i == 3'd2); // R8
      end
      AST_FMT_RANGE: assert (fmt_i <= 3'd5); // R10
   end

endmodule

bind rv_imm_gen rvimm_chk #(.ILEN(ILEN), .XLEN(XLEN)) u_chk (
   .inst_i (inst_i),
   .sel_i  (fmt_sel_i),
   .fmt_i  (fmt_o),
   .imm_i  (imm_o)
);

// File: tb/tb_rv_imm_gen.sv
module tb_rv_imm_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        done = 1'b0;
   logic [31:0] inst = 32'd0;
   logic [2:0]  sel = 3'd0;
   logic [31:0] imm;
   logic [2:0]  fmt;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   rv_imm_gen dut (
      .inst_i    (inst),
      .fmt_sel_i (sel),
      .imm_o     (imm),
      .fmt_o     (fmt)
   );

   // R8: opcode classification model
   function automatic int ref_fmt(input logic [31:0] w, input logic [2:0] s);
      if (s == 3'd0) begin
         case (w[6:0])
            7'b0010011, 7'b0000011, 7'b1100111: return 1;
            7'b0100011:                         return 2;
            7'b1100011:                         return 3;
            7'b0110111, 7'b0010111:             return 4;
            7'b1101111:                         return 5;
            default:                            return 0;
         endcase
      end
      if (s <= 3'd5) return int'(s);   // R1 override
      return 0;                        // R1 reserved codes
   endfunction

   // Behavioural value model built from arithmetic shifts of the word
   function automatic logic [31:0] ref_imm(input logic [31:0] w, input int f);
      logic [31:0] t;
      logic [31:0] top;
      top = 32'($signed(w) >>> 31);
      case (f)
         1: t = 32'($signed(w) >>> 20);
         2: t = (32'($signed(w) >>> 25) << 5) | (32'(w[11:7]));
         3: t = (top << 12) | (32'(w[7]) << 11) | (32'(w[30:25]) << 5)
                | (32'(w[11:8]) << 1);
         4: t = w & 32'hFFFF_F000;
         5: t = (top << 20) | (32'(w[19:12]) << 12) | (32'(w[20]) << 11)
                | (32'(w[30:21]) << 1);
         default: t = 32'd0;
      endcase
      return t;
   endfunction

   function automatic string tag_of(input int f, input logic [2:0] s);
      string t;
      case (f)
         1: t = "R2 R7";
         2: t = "R3 R7";
         3: t = "R4 R7";
         4: t = "R5 R7";
         5: t = "R6 R7";
         default: t = "R9";
      endcase
      if (s == 3'd0) t = {t, " R8"};
      else           t = {t, " R1"};
      return {t, " R10 R11"};
   endfunction

   // Compare on every rising edge; inputs move on falling edges (R11)
   always @(posedge clk) begin
      if (rst_n && run && !done) begin
         int          ef;
         logic [31:0] ei;
         ef = ref_fmt(inst, sel);
         ei = ref_imm(inst, ef);
         n_chk++;
         if (imm !== ei || fmt !== 3'(ef)) begin
            n_fail++;
            $display("FAIL %s inst=%h sel=%0d: imm=%h fmt=%0d, expected imm=%h fmt=%0d",
                     tag_of(ef, sel), inst, sel, imm, fmt, ei, ef);
         end
      end
   end

   task automatic apply(input logic [31:0] w, input logic [2:0] s);
      @(negedge clk);
      inst = w;
      sel  = s;
   endtask

   logic [6:0] opc_tab [8] = '{7'b0010011, 7'b0000011, 7'b1100111, 7'b0100011,
                               7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111};

   initial begin
      // Reset state: zero word in classify mode gives no immediate (R9)
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      run   = 1'b1;
      @(negedge clk);

      // Boundary words in every explicit layout (R1..R7)
      for (int s = 1; s <= 5; s++) begin
         apply(32'hFFFF_FFFF, 3'(s));
         apply(32'h8000_0000, 3'(s));
         apply(32'h7FFF_FFFF, 3'(s));
         apply(32'h0000_0F80, 3'(s));
         apply(32'h0010_0000, 3'(s));
         apply(32'h7E00_0080, 3'(s));
         apply(32'h000F_F000, 3'(s));
      end

      // Every listed opcode in classify mode, both signs (R8)
      for (int k = 0; k < 8; k++) begin
         apply({25'h1AAAAAA, opc_tab[k]}, 3'd0);
         apply({25'h0555555, opc_tab[k]}, 3'd0);
      end

      // Unlisted opcodes and reserved selects give zero (R9, R1)
      apply(32'hFFFF_FF33, 3'd0);
      apply(32'hFFFF_FF7F, 3'd0);
      apply(32'hFFFF_FFEF, 3'd6);
      apply(32'hFFFF_FFEF, 3'd7);

      // Explicit select overrides a jump opcode (R1)
      apply(32'h8765_436F, 3'd2);
      apply(32'h8765_436F, 3'd3);

      // Random words, half with listed opcodes
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] w;
         w = $urandom;
         if (k % 2 == 1) w[6:0] = opc_tab[$urandom_range(0, 7)];
         apply(w, 3'($urandom_range(0, 7)));
      end

      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R11: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule